// File: doc/BRIEF.md
# Trace Synchronization Request Scheduler

This block decides the cycles in which a trace stream has to emit a synchronization offset marker, and which 2-bit reason code that marker carries. A down-counter with a programmable period expires at regular intervals and leaves a pending request. The request is served at the first instruction-executed status cycle that follows while tracing is on. Such a marker replaces the executed status, which the receiver then takes as implied.

Turning tracing on always produces a marker in that same cycle. Its reason comes from the trace-on cause input, and no pipeline status is implied by it. If the period expires a second time before a pending request has been served, the request becomes an overflow. The next marker then carries the overflow reason, and the receiver must assume that trace was lost. The contents of the packet are built elsewhere. This block only issues the strobe, the reason code and the implied-status flag, combinationally in the cycle they apply to.

Top module: `trsync_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `sync_fire`, `sync_why` and `ie_absorbed` are all zero. No request is pending and no overflow is recorded. The first clock edge after release loads the counter from `sync_period` and produces no expiry.
- R2: At each later clock edge, a counter value of zero reloads the counter from `sync_period` as sampled at that edge and marks a periodic request pending. Any other value is decremented. With a constant period P, expiries are therefore P+1 cycles apart.
- R3: A pending request is served only in a cycle where `trace_on` is high, `trace_on` was also high in the previous cycle, and `pipe_stat` equals 4'h1 (instruction executed). In that cycle `sync_fire` is 1, `sync_why` is 2'b00 and `ie_absorbed` is 1. Cycles with any other status value leave the request waiting.
- R4: An expiry that finds a request already pending, and not being served in that cycle, records an overflow. The next served request then gives `sync_why` = 2'b10 and `ie_absorbed` = 0, and the overflow record is cleared.
- R5: In the first cycle in which `trace_on` is high after a low cycle (or after reset), `sync_fire` is 1 and `ie_absorbed` is 0. `sync_why` equals `on_cause`, except that the value 2'b00 is given as 2'b01.
- R6: A trace-on marker takes priority over a pending request in the same cycle. It discards the request and any overflow record. An expiry in that same cycle still leaves a fresh request pending.
- R7: Serving a request clears it. If an expiry coincides with serving, a new request stays pending and no overflow is recorded.
- R8: While `trace_on` is low, `sync_fire` stays 0. Pending requests and overflow records are kept, apart from the discard described in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_on | input | 1 | Tracing enabled |
| pipe_stat | input | 4 | Current pipeline status code, 4'h1 = instruction executed |
| sync_period | input | 12 | Counter reload value |
| on_cause | input | 2 | Reason to report for a trace-on marker |
| sync_fire | output | 1 | Marker issued this cycle |
| sync_why | output | 2 | Reason code of the marker |
| ie_absorbed | output | 1 | Marker replaces an executed status that is implied |

## Verification
A stuck or lost pending flag shows at the ports within one period plus the gap to the next executed cycle: a marker that never comes, or one that arrives early with reason 00. A wrong overflow record appears at the very next served request as reason 10 where 00 was due, or the reverse. A counter that is off by one moves every periodic marker by one cycle and is caught at the first expiry. The bench models all of this cycle by cycle and compares the outputs in every cycle.

// File: rtl/trsync_pkg.sv
package trsync_pkg;
  typedef enum logic [1:0] {
    WHY_PERIODIC = 2'b00,
    WHY_ON_DFLT  = 2'b01,
    WHY_OVERFLOW = 2'b10,
    WHY_ON_ALT   = 2'b11
  } sync_why_e;
endpackage

// File: rtl/trsync_period_ctr.sv
module trsync_period_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  output logic             expire
);
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire = armed_q && (cnt_q == '0);
  assign cnt_en = 1'b1;

  always_comb begin
    armed_d = 1'b1;
    cnt_d   = cnt_q;
    if (!armed_q || cnt_q == '0) cnt_d = period;
    else                         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: an expiry reloads the sampled period
  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(period)));
  // R2: a non-zero count steps down by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/trsync_on_detect.sv
module trsync_on_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic trace_on,
  output logic on_evt,
  output logic on_steady
);
  logic en_q;

  assign on_evt    = trace_on && !en_q;
  assign on_steady = trace_on && en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= trace_on;
  end

  // R5: a trace-on event lasts a single cycle
  a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
    on_evt |=> !on_evt);
endmodule

// File: rtl/trsync_req_track.sv
module trsync_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic on_evt,
  input  logic serve,
  output logic pend_q,
  output logic ovf_q
);
  logic pend_d, ovf_d, drop, keep_en;

  assign drop    = serve || on_evt;
  assign keep_en = 1'b1;

  always_comb begin
    pend_d = expire || (pend_q && !drop);
    ovf_d  = (expire && pend_q && !drop) || (ovf_q && !drop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (keep_en) begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  // R4: an overflow record always comes with a pending request
  a_r4_ovf_pend: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> pend_q);
  // R7: serving without a new expiry leaves nothing pending
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (serve && !expire) |=> (!pend_q && !ovf_q));
  // R6: trace-on discards any overflow record
  a_r6_discard: assert property (@(posedge clk) disable iff (!rst_n)
    on_evt |=> !ovf_q);
endmodule

// File: rtl/trsync_sched.sv
module trsync_sched #(
  parameter int          CNT_W   = 12,
  parameter int          ST_W    = 4,
  parameter logic [3:0]  IE_CODE = 4'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trace_on,
  input  logic [ST_W-1:0]  pipe_stat,
  input  logic [CNT_W-1:0] sync_period,
  input  logic [1:0]       on_cause,
  output logic             sync_fire,
  output logic [1:0]       sync_why,
  output logic             ie_absorbed
);
  import trsync_pkg::*;

  localparam logic [ST_W-1:0] IE_VAL = ST_W'(IE_CODE);

  logic expire, on_evt, on_steady, pend_q, ovf_q, is_ie, serve;
  sync_why_e why;

  trsync_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .period(sync_period), .expire(expire));

  trsync_on_detect u_on (
    .clk(clk), .rst_n(rst_n), .trace_on(trace_on),
    .on_evt(on_evt), .on_steady(on_steady));

  trsync_req_track u_trk (
    .clk(clk), .rst_n(rst_n), .expire(expire), .on_evt(on_evt),
    .serve(serve), .pend_q(pend_q), .ovf_q(ovf_q));

  assign is_ie = (pipe_stat == IE_VAL);
  assign serve = on_steady && pend_q && is_ie;

  always_comb begin
    why = WHY_PERIODIC;
    if (on_evt) begin
      why = (on_cause == 2'b00) ? WHY_ON_DFLT : sync_why_e'(on_cause);
    end else if (serve && ovf_q) begin
      why = WHY_OVERFLOW;
    end
  end

  assign sync_fire   = on_evt || serve;
  assign sync_why    = sync_fire ? why : 2'b00;
  assign ie_absorbed = serve && !ovf_q;

  // R3: an implied status only on a periodic marker over an executed cycle
  a_r3_implied: assert property (@(posedge clk) disable iff (!rst_n)
    ie_absorbed |-> (sync_fire && sync_why == 2'b00 && pipe_stat == IE_VAL));
  // R8: no marker while tracing is off
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_on |-> !sync_fire);
  // R5: turning tracing on always fires with a non-zero reason
  a_r5_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    on_evt |-> (sync_fire && sync_why != 2'b00 && !ie_absorbed));
endmodule

// File: tb/sim_trsync_sched.sv
module sim_trsync_sched;
  logic        clk, rst_n, trace_on;
  logic [3:0]  pipe_stat;
  logic [11:0] sync_period;
  logic [1:0]  on_cause;
  logic        sync_fire, ie_absorbed;
  logic [1:0]  sync_why;

  int checks = 0, failures = 0;
  bit finished = 0;

  // bench model state
  bit m_armed, m_en, m_pend, m_ovf;
  int m_cnt;

  trsync_sched u0 (
    .clk(clk), .rst_n(rst_n), .trace_on(trace_on), .pipe_stat(pipe_stat),
    .sync_period(sync_period), .on_cause(on_cause),
    .sync_fire(sync_fire), .sync_why(sync_why), .ie_absorbed(ie_absorbed));

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [3:0] exp_vec(input bit en, input logic [3:0] ps,
                                         input logic [1:0] cause);
    bit on, srv;
    logic [1:0] w;
    on  = en && !m_en;
    srv = en && m_en && m_pend && (ps == 4'h1);
    w   = 2'b00;
    if (on) w = (cause == 2'b00) ? 2'b01 : cause;
    else if (srv && m_ovf) w = 2'b10;
    return {on || srv, w, srv && !m_ovf};
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s fire/why/ie actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit en, input logic [3:0] ps, input logic [11:0] per,
                      input logic [1:0] cause);
    logic [3:0] e;
    bit on, srv, ex, drop;
    string tag;
    @(negedge clk);
    trace_on = en; pipe_stat = ps; sync_period = per; on_cause = cause;
    #2;
    e   = exp_vec(en, ps, cause);
    on  = en && !m_en;
    srv = en && m_en && m_pend && (ps == 4'h1);
    if (on) tag = "R5";
    else if (srv && m_ovf) tag = "R4";
    else if (srv) tag = "R3";
    else if (!en) tag = "R8";
    else tag = "R2";
    check(tag, {sync_fire, sync_why, ie_absorbed}, e);
    // advance model to the next clock edge
    ex   = m_armed && (m_cnt == 0);
    drop = on || srv;
    m_ovf  = (ex && m_pend && !drop) || (m_ovf && !drop);
    m_pend = ex || (m_pend && !drop);
    if (!m_armed || m_cnt == 0) m_cnt = per; else m_cnt = m_cnt - 1;
    m_armed = 1;
    m_en = en;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 0; trace_on = 0; pipe_stat = 0; sync_period = 12'd3; on_cause = 0;
    m_armed = 0; m_en = 0; m_pend = 0; m_ovf = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1", {sync_fire, sync_why, ie_absorbed}, 4'b0000);
    @(negedge clk); rst_n = 1;
    check("R1", {sync_fire, sync_why, ie_absorbed}, 4'b0000);

    // R5: trace-on with cause 00 reports 01
    step(1, 4'h0, 12'd2, 2'b00);
    // R2/R3: period 2, non-IE cycles then an IE cycle gives a periodic marker
    repeat (3) step(1, 4'h3, 12'd2, 2'b00);
    step(1, 4'h1, 12'd2, 2'b00);
    // R4: several expiries with no IE, then IE gives the overflow reason
    repeat (8) step(1, 4'h2, 12'd2, 2'b00);
    step(1, 4'h1, 12'd2, 2'b00);
    step(1, 4'h1, 12'd2, 2'b00);
    // R8: trace off while pending, IE ignored
    repeat (6) step(0, 4'h1, 12'd2, 2'b11);
    // R6: trace back on with cause 11 while a request is pending
    step(1, 4'h1, 12'd2, 2'b11);
    // R7: period 0 expires every cycle, IE serves and keeps one pending
    repeat (6) step(1, 4'h1, 12'd0, 2'b00);
    repeat (4) step(1, 4'h5, 12'd0, 2'b10);
    step(1, 4'h1, 12'd0, 2'b00);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      bit en;
      logic [3:0] ps;
      en = ($urandom_range(0, 39) == 0) ? !trace_on : trace_on;
      ps = ($urandom_range(0, 5) == 0) ? 4'h1 : 4'($urandom_range(2, 15));
      step(en, ps, 12'($urandom_range(0, 12)), 2'($urandom_range(0, 3)));
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule